// File: doc/BRIEF.md
# DS3 Overhead Bit Insertion Controller

This block sits beside a DS3 framer on the terminal-equipment side of the framer's transmit overhead input port. On every rising edge of the DS3 line clock it samples two strobes from the framer. The first is an overhead-enable strobe, which warns that the framer is about to process an overhead bit. The second is a frame strobe. When both strobes are high together, they mark the first overhead bit of a new DS3 frame.

The block counts enable strobes from that marker onward, so it always knows which overhead position comes next. Some positions accept outside data: position 0 (X), position 2 (AIC) and position 4 (NA). For these, if software has enabled the position, the block raises an insert request and drives the stored overhead value on the data output. It never inserts at the framing positions 1 (F1) and 3 (F0), at positions beyond 4, or before it has seen a frame marker.

Software stores the overhead values through a small write port. Each position has one value bit and one insert-enable bit.

Top module: `ds3oh_inserter`

## Requirements
- R1: A synchronous active-high reset clears all stored values and enables, clears the position tracking and the locked state, and holds `oh_ins` and `oh_data` at 0 in the cycle after every clock edge at which reset is high.
- R2: After reset, no insert request is raised until a clock edge samples `oh_en` and `oh_frame` high together. Enable strobes before that point are ignored.
- R3: An edge that samples `oh_en` and `oh_frame` both high marks position 0 (X) and restarts the count. It does so whether or not the block was already locked.
- R4: Each later edge with `oh_en` high and `oh_frame` low moves to the next position: 1, 2, 3, 4, then beyond. Edges with `oh_en` low leave the position unchanged, however many of them occur.
- R5: Positions 1 (F1) and 3 (F0) never produce an insert request, whatever their stored enable and value bits hold.
- R6: When an enable strobe is sampled at position 0, 2 or 4, and that position's enable bit is set, `oh_ins` is 1 and `oh_data` equals the position's value bit. Both are registered and valid during the single clock cycle that follows the sampling edge.
- R7: For positions beyond 4, and for positions 0, 2 and 4 whose enable bit is clear, `oh_ins` stays 0 and `oh_data` is 0.
- R8: A write with `cfg_wr` high stores `cfg_val` and `cfg_ena` for the position given by `cfg_addr`; address value p selects position p. The new value takes effect from the following clock edge, so a strobe sampled at the same edge as the write uses the old contents. Writes to addresses 5 to 7 change nothing.
- R9: An edge with `oh_frame` high and `oh_en` low neither restarts nor advances the position count.
- R10: In any cycle that does not follow an edge at which `oh_en` was sampled high, `oh_ins` and `oh_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DS3 line clock (44.736 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| oh_en | input | 1 | Overhead-enable strobe from the framer |
| oh_frame | input | 1 | Frame strobe from the framer |
| cfg_wr | input | 1 | Write strobe of the configuration port |
| cfg_addr | input | 3 | Overhead position to write |
| cfg_val | input | 1 | Overhead value to store |
| cfg_ena | input | 1 | Insert-enable bit to store |
| oh_ins | output | 1 | Insert request to the framer |
| oh_data | output | 1 | Overhead data to the framer |

## Verification
The position update and the output drive share one register stage. So the insert request and data for a strobe sampled at clock edge k are due in the cycle between edges k and k+1, and are gone by edge k+1. A configuration write sampled at edge k first affects a strobe sampled at edge k+1.

The bench drives inputs shortly after each rising edge. Its behavioural model advances at the same rising edge as the design. The outputs are compared at the falling edge, which is the middle of the cycle in which the result is due. Strobe trains are run with gaps, back to back, before lock, past position 4, and with a write landing on the same edge as a strobe.

// File: rtl/ds3oh_pkg.sv
package ds3oh_pkg;

    // Overhead positions counted from the frame marker
    typedef enum logic [2:0] {
        POS_X   = 3'd0,
        POS_F1  = 3'd1,
        POS_AIC = 3'd2,
        POS_F0  = 3'd3,
        POS_NA  = 3'd4
    } ohpos_e;

    // Registered drive towards the framer
    typedef struct packed {
        logic ins;
        logic data;
    } oh_drive_t;

    // True for the positions the framer lets the terminal overwrite
    function automatic logic pos_insertable(input int unsigned p);
        return (p == int'(POS_X)) || (p == int'(POS_AIC)) || (p == int'(POS_NA));
    endfunction

endpackage

// File: rtl/ds3oh_pos_tracker.sv
module ds3oh_pos_tracker #(
    parameter int unsigned POS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oh_en,
    input  logic             oh_frame,
    output logic             cur_hit,
    output logic [POS_W-1:0] cur_pos
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef struct packed {
        logic             locked;
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d   = trk_q;
        cur_hit = 1'b0;
        if (oh_frame) begin
            cur_pos = '0;
        end else if (trk_q.pos == POS_MAX) begin
            cur_pos = POS_MAX;
        end else begin
            cur_pos = trk_q.pos + 1'b1;
        end
        if (oh_en && (oh_frame || trk_q.locked)) begin
            cur_hit      = 1'b1;
            trk_d.locked = 1'b1;
            trk_d.pos    = cur_pos;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/ds3oh_cfg_regs.sv
module ds3oh_cfg_regs #(
    parameter int unsigned NPOS = 5,
    parameter int unsigned AW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [AW-1:0]   cfg_addr,
    input  logic            cfg_val,
    input  logic            cfg_ena,
    output logic [NPOS-1:0] val_q,
    output logic [NPOS-1:0] ena_q
);
    typedef struct packed {
        logic [NPOS-1:0] val;
        logic [NPOS-1:0] ena;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int p = 0; p < int'(NPOS); p++) begin
            if (cfg_wr && (cfg_addr == AW'(p))) begin
                cfg_d.val[p] = cfg_val;
                cfg_d.ena[p] = cfg_ena;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign val_q = cfg_q.val;
    assign ena_q = cfg_q.ena;

endmodule

// File: rtl/ds3oh_inserter.sv
module ds3oh_inserter #(
    parameter int unsigned NPOS  = 5,
    parameter int unsigned POS_W = 4,
    parameter int unsigned AW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          oh_en,
    input  logic          oh_frame,
    input  logic          cfg_wr,
    input  logic [AW-1:0] cfg_addr,
    input  logic          cfg_val,
    input  logic          cfg_ena,
    output logic          oh_ins,
    output logic          oh_data
);
    import ds3oh_pkg::*;

    logic             cur_hit;
    logic [POS_W-1:0] cur_pos;
    logic [NPOS-1:0]  val_q;
    logic [NPOS-1:0]  ena_q;
    logic [NPOS-1:0]  sel;

    oh_drive_t drv_d, drv_q;

    ds3oh_pos_tracker #(.POS_W(POS_W)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .oh_en    (oh_en),
        .oh_frame (oh_frame),
        .cur_hit  (cur_hit),
        .cur_pos  (cur_pos)
    );

    ds3oh_cfg_regs #(.NPOS(NPOS), .AW(AW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_val  (cfg_val),
        .cfg_ena  (cfg_ena),
        .val_q    (val_q),
        .ena_q    (ena_q)
    );

    // One-hot select for the insertable positions only
    for (genvar g = 0; g < int'(NPOS); g++) begin : g_sel
        if (pos_insertable(g)) begin : g_acc
            assign sel[g] = cur_hit && (cur_pos == POS_W'(g)) && ena_q[g];
        end else begin : g_rej
            assign sel[g] = 1'b0;
        end
    end

    always_comb begin
        drv_d.ins  = |sel;
        drv_d.data = |(sel & val_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign oh_ins  = drv_q.ins;
    assign oh_data = drv_q.data;

endmodule

// File: rtl/ds3oh_inserter_chk.sv
module ds3oh_inserter_chk (
    input logic clk,
    input logic rst,
    input logic oh_en,
    input logic oh_frame,
    input logic oh_ins,
    input logic oh_data
);
    logic seen_q;
    int   cpos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            cpos_q <= 0;
        end else if (oh_en) begin
            if (oh_frame) begin
                seen_q <= 1'b1;
                cpos_q <= 0;
            end else if (cpos_q < 100) begin
                cpos_q <= cpos_q + 1;
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!oh_ins && !oh_data));

    p_unlocked_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!seen_q && !(oh_en && oh_frame)) |=> !oh_ins);

    p_framing_never_r5: assert property (@(posedge clk) disable iff (rst)
        (seen_q && oh_en && !oh_frame && (cpos_q == 0 || cpos_q == 2)) |=> !oh_ins);

    p_data_needs_ins_r6: assert property (@(posedge clk) disable iff (rst)
        oh_data |-> oh_ins);

    p_beyond_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (seen_q && oh_en && !oh_frame && cpos_q >= 4) |=> (!oh_ins && !oh_data));

    p_lone_frame_r9: assert property (@(posedge clk) disable iff (rst)
        (oh_frame && !oh_en) |=> !oh_ins);

    p_no_strobe_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !oh_en |=> (!oh_ins && !oh_data));

endmodule

bind ds3oh_inserter ds3oh_inserter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .oh_en    (oh_en),
    .oh_frame (oh_frame),
    .oh_ins   (oh_ins),
    .oh_data  (oh_data)
);

// File: tb/tb_ds3oh_inserter.sv
`timescale 1ns/1ps
module tb_ds3oh_inserter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       oh_en = 1'b0;
    logic       oh_frame = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic       cfg_val = 1'b0;
    logic       cfg_ena = 1'b0;
    logic       oh_ins;
    logic       oh_data;

    always #4 clk = ~clk;

    ds3oh_inserter dut (
        .clk(clk), .rst(rst), .oh_en(oh_en), .oh_frame(oh_frame),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_val(cfg_val),
        .cfg_ena(cfg_ena), .oh_ins(oh_ins), .oh_data(oh_data)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    done = 0;
    string phase = "R1 reset";

    // Behavioural reference model
    bit m_locked = 0;
    int m_pos = 0;
    bit m_val[5];
    bit m_ena[5];
    bit exp_ins = 0;
    bit exp_data = 0;

    always @(posedge clk) begin
        started = 1;
        cycles++;
        exp_ins  = 0;
        exp_data = 0;
        if (rst) begin
            m_locked = 0;
            m_pos = 0;
            for (int i = 0; i < 5; i++) begin
                m_val[i] = 0;
                m_ena[i] = 0;
            end
        end else begin
            if (oh_en) begin
                if (oh_frame) begin
                    m_locked = 1;
                    m_pos = 0;
                end else if (m_locked) begin
                    m_pos = m_pos + 1;
                end
                if (m_locked && (m_pos == 0 || m_pos == 2 || m_pos == 4) && m_ena[m_pos]) begin
                    exp_ins  = 1;
                    exp_data = m_val[m_pos];
                end
            end
            if (cfg_wr && cfg_addr < 5) begin
                m_val[cfg_addr] = cfg_val;
                m_ena[cfg_addr] = cfg_ena;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (oh_ins !== exp_ins || oh_data !== exp_data) begin
                errors++;
                $display("FAIL %s: ins=%b exp %b, data=%b exp %b at %0t",
                         phase, oh_ins, exp_ins, oh_data, exp_data, $time);
            end
        end
    end

    task automatic quiet(input int n);
        repeat (n) begin
            @(posedge clk); #2;
            oh_en = 0; oh_frame = 0; cfg_wr = 0;
        end
    endtask

    task automatic strobe(input bit fr);
        @(posedge clk); #2;
        oh_en = 1; oh_frame = fr; cfg_wr = 0;
    endtask

    task automatic wr(input logic [2:0] a, input bit v, input bit e);
        @(posedge clk); #2;
        oh_en = 0; oh_frame = 0;
        cfg_wr = 1; cfg_addr = a; cfg_val = v; cfg_ena = e;
    endtask

    task automatic frame_train(input int n, input int gap);
        strobe(1);
        quiet(gap);
        for (int i = 1; i < n; i++) begin
            strobe(0);
            quiet(gap);
        end
    endtask

    initial begin
        quiet(3);
        rst = 0;
        phase = "R8 config write";
        wr(3'd0, 1, 1); wr(3'd1, 1, 1); wr(3'd2, 0, 1);
        wr(3'd3, 1, 1); wr(3'd4, 1, 1);
        quiet(1);
        phase = "R2 strobes before lock";
        for (int i = 0; i < 6; i++) begin strobe(0); quiet(2); end
        phase = "R9 frame without enable";
        @(posedge clk); #2; oh_frame = 1; oh_en = 0;
        quiet(1);
        strobe(0); quiet(2);
        phase = "R3 R4 R5 R6 R7 gapped train";
        frame_train(8, 3);
        phase = "R4 back-to-back train";
        frame_train(7, 0);
        quiet(2);
        phase = "R8 write lands on strobe edge";
        strobe(1); quiet(1);
        strobe(0); quiet(1);
        @(posedge clk); #2;
        oh_en = 1; oh_frame = 0;
        cfg_wr = 1; cfg_addr = 3'd2; cfg_val = 1; cfg_ena = 1;
        quiet(1);
        phase = "R8 R7 disable NA and ignored addresses";
        wr(3'd4, 1, 0); wr(3'd5, 1, 1); wr(3'd6, 1, 1); wr(3'd7, 0, 0);
        quiet(1);
        frame_train(6, 1);
        phase = "R3 relock mid frame";
        strobe(1); quiet(1); strobe(0); quiet(1);
        strobe(1); quiet(1); strobe(0); quiet(1); strobe(0); quiet(2);
        phase = "R7 X disabled";
        wr(3'd0, 1, 0);
        frame_train(5, 2);
        phase = "R1 mid-run reset";
        @(posedge clk); #2; rst = 1; oh_en = 1; oh_frame = 1;
        quiet(2);
        rst = 0;
        phase = "R2 after reset";
        for (int i = 0; i < 4; i++) begin strobe(0); quiet(1); end
        phase = "R1 config cleared by reset";
        frame_train(5, 1);
        phase = "R6 relock after reconfig";
        wr(3'd0, 0, 1); wr(3'd4, 1, 1);
        frame_train(5, 2);
        quiet(4);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: ran %0d cycles, expected under %0d", cycles, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule